// File: doc/BRIEF.md
# Dual-Clock Split-Capable Write Posting Buffer

This block posts 64-bit write words, each with 8 byte-parity bits, from a system clock domain into a memory clock domain. The storage holds 16 words. It runs either as one 16-word queue or, when the static split input is high, as two independent 8-word queues: queue A in the lower half of the storage and queue B in the upper half. A 2-bit queue code chooses which queue is cleared or addressed. The code is brought into each clock domain through its own synchronizer, so it is held steady for several cycles of the slower clock whenever it changes.

The system side pushes a word on a rising system-clock edge while the active-low write strobe is low. The memory side sees the oldest word of the addressed queue on its output at once, with no read latency. It pops that word on a rising memory-clock edge while the active-low read strobe is low. Each queue keeps Gray-coded pointers that cross the domains through two-flop synchronizers. The full flag is formed in the system domain and the empty flag in the memory domain. A steering input picks the queue head or a locally captured system-side holding register as the memory-side data.

Top module: `posted_write_buffer`

## Requirements
- R1: After reset is released with queue code 10, the addressed queue reports not full (`wr_full` = 0) and empty (`rd_empty` = 1).
- R2: A word {`sys_par`, `sys_data`} is pushed on a rising `sys_clk` edge when `wr_n` is low and the addressed queue is not full. A word is popped on a rising `mem_clk` edge when `rd_n` is low and the addressed queue is not empty.
- R3: With `buf_sel` high and the addressed queue not empty, {`mem_par`, `mem_data`} shows the oldest unread word of that queue, and words leave in the order they entered, including after the pointers wrap.
- R4: With `split_mode` low, the queue holds exactly 16 words. `wr_full` is 1 once 16 words are unread, and a push attempted while full is dropped.
- R5: With `split_mode` high, code 10 addresses queue A and code 11 addresses queue B. Each holds 8 words independently of the other.
- R6: Code 00 empties queue A (the single queue when not split). Code 01 with `split_mode` high empties queue B. The other queue keeps its contents.
- R7: Codes 00 and 01 address no queue, and neither do 01 and 11 when `split_mode` is low; 01 then clears nothing. While no queue is addressed, `wr_full` = 1, `rd_empty` = 1, and write and read strobes have no effect.
- R8: A pop attempted while the addressed queue is empty is dropped and leaves its read position unchanged.
- R9: With `buf_sel` low, {`mem_par`, `mem_data`} shows the holding register. That register captures {`sys_par`, `sys_data`} on each rising `sys_clk` edge where `lat_en` is high and holds it otherwise.
- R10: `rd_empty` falls within 4 `mem_clk` cycles after a push into an empty queue. `wr_full` falls within 4 `sys_clk` cycles after a pop from a full queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System-side clock |
| mem_clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| split_mode | input | 1 | Static: 0 = one 16-word queue, 1 = two 8-word queues |
| qcode | input | 2 | Queue code: 00 clear A, 01 clear B, 10 address A, 11 address B |
| wr_n | input | 1 | Active-low push strobe (system domain) |
| sys_data | input | 64 | Write data |
| sys_par | input | 8 | Byte parity travelling with the data |
| lat_en | input | 1 | Holding register capture enable (system domain) |
| rd_n | input | 1 | Active-low pop strobe (memory domain) |
| buf_sel | input | 1 | 1 = queue head, 0 = holding register to the memory side |
| mem_data | output | 64 | Memory-side data |
| mem_par | output | 8 | Memory-side parity |
| wr_full | output | 1 | Addressed queue full, or nothing addressed (system domain) |
| rd_empty | output | 1 | Addressed queue empty, or nothing addressed (memory domain) |

## Verification
The hardest situation to reach from the ports is clearing one half in split mode while the other half holds unread data. Both domains must see the clear code and the cleared pointers must cross back before the half is addressed again, and only then can a read of the surviving half show that its order is intact. The stimulus loads eight words into queue A and eight into queue B, clears B under a held code, and reads two words from A. It then confirms that B is empty and still usable, and drains the rest of A. Ignored codes in the single-queue mode get the same treatment: the bench pulses both strobes under each ignored code and later reads back every stored word.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    QC_CLR_A = 2'b00,
    QC_CLR_B = 2'b01,
    QC_SEL_A = 2'b10,
    QC_SEL_B = 2'b11
  } qcode_e;

  typedef struct packed {
    logic clr_a;
    logic clr_b;
    logic sel_a;
    logic sel_b;
  } qctl_t;

  // Second half is only meaningful when the storage is split.
  function automatic qctl_t decode_qcode(logic [1:0] code, logic split);
    qctl_t r;
    r = '0;
    case (qcode_e'(code))
      QC_CLR_A: r.clr_a = 1'b1;
      QC_CLR_B: r.clr_b = split;
      QC_SEL_A: r.sel_a = 1'b1;
      QC_SEL_B: r.sel_b = split;
      default:  r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pwb_rst_sync.sv
module pwb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;
endmodule

// File: rtl/pwb_sync2.sv
module pwb_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/pwb_wr_side.sv
module pwb_wr_side #(
  parameter int DEPTH = 16,
  parameter int QID   = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       split,
  input  logic                       clr,
  input  logic                       sel,
  input  logic                       wr_req,
  input  logic [$clog2(DEPTH):0]     rgray_i,
  output logic [$clog2(DEPTH):0]     gray_o,
  output logic [$clog2(DEPTH)-1:0]   addr_o,
  output logic                       full_o,
  output logic                       take_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PTRW = AW + 1;
  localparam int HALF = DEPTH / 2;
  localparam logic [PTRW-1:0] CAP_FULL = PTRW'(DEPTH);
  localparam logic [PTRW-1:0] CAP_HALF = PTRW'(HALF);
  localparam logic QBIT = (QID == 1);

  logic [PTRW-1:0] bin_q, bin_d, gray_q, gray_d;
  logic [PTRW-1:0] rgray_s, rbin_s, used, cap;

  pwb_sync2 #(.W(PTRW)) u_rsync (
    .clk(clk), .rst_n(rst_n), .d(rgray_i), .q(rgray_s)
  );

  for (genvar i = 0; i < PTRW; i++) begin : g_g2b
    assign rbin_s[i] = ^rgray_s[PTRW-1:i];
  end

  // Queue B has no room when the storage is not split.
  assign cap    = split ? CAP_HALF : (QBIT ? '0 : CAP_FULL);
  assign used   = bin_q - rbin_s;
  assign full_o = (used >= cap);
  assign take_o = sel & wr_req & ~full_o & ~clr;

  always_comb begin
    bin_d = bin_q;
    if (clr)         bin_d = '0;
    else if (take_o) bin_d = bin_q + 1'b1;
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign gray_o = gray_q;
  assign addr_o = {QBIT | (bin_q[AW-1] & ~split), bin_q[AW-2:0]};

  a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> (used <= cap));
  a_r4_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && full_o) |=> (bin_q == $past(bin_q)));
  a_r10_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ($countones(gray_q ^ $past(gray_q)) <= 1));
endmodule

// File: rtl/pwb_rd_side.sv
module pwb_rd_side #(
  parameter int DEPTH = 16,
  parameter int QID   = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       split,
  input  logic                       clr,
  input  logic                       sel,
  input  logic                       rd_req,
  input  logic [$clog2(DEPTH):0]     wgray_i,
  output logic [$clog2(DEPTH):0]     gray_o,
  output logic [$clog2(DEPTH)-1:0]   addr_o,
  output logic                       empty_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PTRW = AW + 1;
  localparam logic QBIT = (QID == 1);

  logic [PTRW-1:0] bin_q, bin_d, gray_q, gray_d, wgray_s;
  logic            take;

  pwb_sync2 #(.W(PTRW)) u_wsync (
    .clk(clk), .rst_n(rst_n), .d(wgray_i), .q(wgray_s)
  );

  assign empty_o = (wgray_s == gray_q);
  assign take    = sel & rd_req & ~empty_o & ~clr;

  always_comb begin
    bin_d = bin_q;
    if (clr)       bin_d = '0;
    else if (take) bin_d = bin_q + 1'b1;
    gray_d = bin_d ^ (bin_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign gray_o = gray_q;
  assign addr_o = {QBIT | (bin_q[AW-1] & ~split), bin_q[AW-2:0]};

  a_r8_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && empty_o) |=> (bin_q == $past(bin_q)));
  a_r10_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ($countones(gray_q ^ $past(gray_q)) <= 1));
endmodule

// File: rtl/pwb_store.sv
module pwb_store #(
  parameter int DEPTH = 16,
  parameter int W     = 72
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/posted_write_buffer.sv
module posted_write_buffer #(
  parameter int DATA_W = 64,
  parameter int PAR_W  = 8,
  parameter int DEPTH  = 16
) (
  input  logic              sys_clk,
  input  logic              mem_clk,
  input  logic              rst_n,
  input  logic              split_mode,
  input  logic [1:0]        qcode,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] sys_data,
  input  logic [PAR_W-1:0]  sys_par,
  input  logic              lat_en,
  input  logic              rd_n,
  input  logic              buf_sel,
  output logic [DATA_W-1:0] mem_data,
  output logic [PAR_W-1:0]  mem_par,
  output logic              wr_full,
  output logic              rd_empty
);
  import pwb_pkg::*;

  localparam int AW   = $clog2(DEPTH);
  localparam int PTRW = AW + 1;
  localparam int WW   = DATA_W + PAR_W;
  localparam int NQ   = 2;

  logic            rst_w_n, rst_r_n;
  logic [1:0]      code_w, code_r;
  qctl_t           ctl_w, ctl_r;
  logic [NQ-1:0]   clr_w, sel_w, clr_r, sel_r;
  logic [NQ-1:0]   full_w, take_w, empty_r;
  logic [PTRW-1:0] wgray [NQ];
  logic [PTRW-1:0] rgray [NQ];
  logic [AW-1:0]   waddr [NQ];
  logic [AW-1:0]   raddr [NQ];
  logic [AW-1:0]   st_waddr, st_raddr;
  logic [WW-1:0]   head, hold_q, hold_d;

  pwb_rst_sync u_rst_w (.clk(sys_clk), .rst_n(rst_n), .rst_n_o(rst_w_n));
  pwb_rst_sync u_rst_r (.clk(mem_clk), .rst_n(rst_n), .rst_n_o(rst_r_n));

  pwb_sync2 #(.W(2)) u_code_w (.clk(sys_clk), .rst_n(rst_w_n), .d(qcode), .q(code_w));
  pwb_sync2 #(.W(2)) u_code_r (.clk(mem_clk), .rst_n(rst_r_n), .d(qcode), .q(code_r));

  assign ctl_w = decode_qcode(code_w, split_mode);
  assign ctl_r = decode_qcode(code_r, split_mode);
  assign clr_w = {ctl_w.clr_b, ctl_w.clr_a};
  assign sel_w = {ctl_w.sel_b, ctl_w.sel_a};
  assign clr_r = {ctl_r.clr_b, ctl_r.clr_a};
  assign sel_r = {ctl_r.sel_b, ctl_r.sel_a};

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    pwb_wr_side #(.DEPTH(DEPTH), .QID(q)) u_wr (
      .clk(sys_clk), .rst_n(rst_w_n), .split(split_mode),
      .clr(clr_w[q]), .sel(sel_w[q]), .wr_req(~wr_n),
      .rgray_i(rgray[q]), .gray_o(wgray[q]), .addr_o(waddr[q]),
      .full_o(full_w[q]), .take_o(take_w[q])
    );
    pwb_rd_side #(.DEPTH(DEPTH), .QID(q)) u_rd (
      .clk(mem_clk), .rst_n(rst_r_n), .split(split_mode),
      .clr(clr_r[q]), .sel(sel_r[q]), .rd_req(~rd_n),
      .wgray_i(wgray[q]), .gray_o(rgray[q]), .addr_o(raddr[q]),
      .empty_o(empty_r[q])
    );
  end

  assign st_waddr = take_w[1] ? waddr[1] : waddr[0];
  assign st_raddr = sel_r[1]  ? raddr[1] : raddr[0];

  pwb_store #(.DEPTH(DEPTH), .W(WW)) u_store (
    .clk(sys_clk), .we(|take_w), .waddr(st_waddr),
    .wdata({sys_par, sys_data}), .raddr(st_raddr), .rdata(head)
  );

  // Nothing addressed: report both flags so no strobe is honoured.
  assign wr_full  = ~(|sel_w) | |(sel_w & full_w);
  assign rd_empty = ~(|sel_r) | |(sel_r & empty_r);

  always_comb begin
    hold_d = hold_q;
    if (lat_en) hold_d = {sys_par, sys_data};
  end

  always_ff @(posedge sys_clk or negedge rst_w_n) begin
    if (!rst_w_n) hold_q <= '0;
    else          hold_q <= hold_d;
  end

  assign {mem_par, mem_data} = buf_sel ? head : hold_q;

  a_r5_one_writer: assert property (@(posedge sys_clk) disable iff (!rst_w_n)
    $onehot0(take_w));
  a_r7_idle_quiet: assert property (@(posedge sys_clk) disable iff (!rst_w_n)
    (sel_w == '0) |-> (take_w == '0));
endmodule

// File: tb/sim_posted_write_buffer.sv
module sim_posted_write_buffer;
  logic        sys_clk = 1'b0, mem_clk = 1'b0;
  logic        rst_n, split_mode, wr_n, rd_n, lat_en, buf_sel;
  logic [1:0]  qcode;
  logic [63:0] sys_data, mem_data;
  logic [7:0]  sys_par, mem_par;
  logic        wr_full, rd_empty;
  int          total = 0, bad = 0;

  always #10 sys_clk = ~sys_clk;
  always #17 mem_clk = ~mem_clk;

  posted_write_buffer u0 (
    .sys_clk(sys_clk), .mem_clk(mem_clk), .rst_n(rst_n), .split_mode(split_mode),
    .qcode(qcode), .wr_n(wr_n), .sys_data(sys_data), .sys_par(sys_par),
    .lat_en(lat_en), .rd_n(rd_n), .buf_sel(buf_sel), .mem_data(mem_data),
    .mem_par(mem_par), .wr_full(wr_full), .rd_empty(rd_empty)
  );

  function automatic logic [71:0] pat(int i);
    return {8'(i * 29 + 3), 32'hC0DE0000 + 32'(i), 32'(i) ^ 32'h5A5A5A5A};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic split);
    rst_n = 1'b0; split_mode = split; qcode = 2'b00;
    wr_n = 1'b1; rd_n = 1'b1; lat_en = 1'b0; buf_sel = 1'b1;
    sys_data = '0; sys_par = '0;
    repeat (3) @(negedge mem_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge mem_clk);
  endtask

  task automatic set_code(input logic [1:0] c);
    @(negedge sys_clk) qcode = c;
    repeat (6) @(negedge mem_clk);
  endtask

  task automatic settle();
    repeat (6) @(negedge mem_clk);
  endtask

  task automatic push(input int i);
    @(negedge sys_clk);
    {sys_par, sys_data} = pat(i);
    wr_n = 1'b0;
    @(negedge sys_clk) wr_n = 1'b1;
  endtask

  task automatic pulse_rd();
    @(negedge mem_clk) rd_n = 1'b0;
    @(negedge mem_clk) rd_n = 1'b1;
  endtask

  task automatic pop_chk(input int i, input string tag);
    @(negedge mem_clk);
    chk({mem_par, mem_data} === pat(i), tag, {mem_par, mem_data}, pat(i));
    rd_n = 1'b0;
    @(negedge mem_clk) rd_n = 1'b1;
  endtask

  task automatic chk_flags(input logic f, input logic e, input string tag);
    @(negedge sys_clk) chk(wr_full === f, {tag, " wr_full"}, 72'(wr_full), 72'(f));
    @(negedge mem_clk) chk(rd_empty === e, {tag, " rd_empty"}, 72'(rd_empty), 72'(e));
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    chk_flags(1'b1, 1'b1, "R7 code00 idle");
    set_code(2'b10);
    chk_flags(1'b0, 1'b1, "R1 after reset");
  endtask

  task automatic t_fill_unified();
    push(0);
    repeat (4) @(negedge mem_clk);
    chk(rd_empty === 1'b0, "R10 empty falls", 72'(rd_empty), 72'(0));
    for (int i = 1; i < 16; i++) push(i);
    chk_flags(1'b1, 1'b0, "R4 full at 16");
    push(99);
    pop_chk(0, "R3 head 0");
    repeat (4) @(negedge sys_clk);
    chk(wr_full === 1'b0, "R10 full falls", 72'(wr_full), 72'(0));
    for (int i = 1; i < 16; i++) pop_chk(i, "R4 order after dropped push");
    settle();
    chk_flags(1'b0, 1'b1, "R2 drained");
    for (int i = 40; i < 45; i++) push(i);
    settle();
    for (int i = 40; i < 45; i++) pop_chk(i, "R3 wrap order");
  endtask

  task automatic t_empty_read();
    settle();
    repeat (3) pulse_rd();
    push(7);
    settle();
    pop_chk(7, "R8 pop on empty dropped");
    settle();
    chk(rd_empty === 1'b1, "R8 empty after one", 72'(rd_empty), 72'(1));
  endtask

  task automatic t_ignored_codes();
    for (int i = 50; i < 54; i++) push(i);
    set_code(2'b01);
    chk_flags(1'b1, 1'b1, "R7 code01 unified");
    push(60); pulse_rd();
    set_code(2'b11);
    chk_flags(1'b1, 1'b1, "R7 code11 unified");
    push(61); pulse_rd();
    set_code(2'b10);
    settle();
    for (int i = 50; i < 54; i++) pop_chk(i, "R7 contents kept");
    settle();
    chk(rd_empty === 1'b1, "R7 no extra word", 72'(rd_empty), 72'(1));
    for (int i = 0; i < 3; i++) push(70 + i);
    set_code(2'b00);
    set_code(2'b10);
    chk_flags(1'b0, 1'b1, "R6 clear unified");
  endtask

  task automatic t_split();
    do_reset(1'b1);
    set_code(2'b10);
    for (int i = 100; i < 108; i++) push(i);
    chk_flags(1'b1, 1'b0, "R5 A full at 8");
    set_code(2'b11);
    chk_flags(1'b0, 1'b1, "R5 B independent");
    for (int i = 200; i < 208; i++) push(i);
    push(250);
    chk_flags(1'b1, 1'b0, "R5 B full at 8");
    set_code(2'b01);
    set_code(2'b10);
    pop_chk(100, "R6 A survives clear of B");
    pop_chk(101, "R6 A order");
    set_code(2'b11);
    chk_flags(1'b0, 1'b1, "R6 B cleared");
    push(300);
    settle();
    pop_chk(300, "R5 B after clear");
    set_code(2'b10);
    for (int i = 102; i < 108; i++) pop_chk(i, "R5 A rest");
    settle();
    chk(rd_empty === 1'b1, "R5 A drained", 72'(rd_empty), 72'(1));
  endtask

  task automatic t_bypass();
    @(negedge sys_clk);
    {sys_par, sys_data} = pat(500);
    lat_en = 1'b1;
    @(negedge sys_clk);
    lat_en = 1'b0;
    {sys_par, sys_data} = pat(501);
    buf_sel = 1'b0;
    @(negedge sys_clk);
    @(negedge mem_clk);
    chk({mem_par, mem_data} === pat(500), "R9 holding register", {mem_par, mem_data}, pat(500));
    buf_sel = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge sys_clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_unified();
    t_empty_read();
    t_ignored_codes();
    t_split();
    t_bypass();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule